// File: doc/BRIEF.md
# Master/Slave Timer Trigger Pair

This block holds two up-counting timers clocked from one kernel clock. The first (master) timer presents one of its internal events on a trigger line, selected by a mode field. The second (slave) timer picks its trigger input with a source-select field and, in trigger mode, turns its own counter enable on by hardware at the first rising edge of that trigger. From then on it keeps counting whatever the trigger does. Each detected trigger edge also sets a sticky flag, which software clears by writing zero.

Both timers have a prescaler, a counter and a reload limit. All fields are set through one write-only register port. The slave's enable, its flag, both counter values and the trigger line are brought out as plain outputs. A typical use is to chain the two timers so that a master reload starts the slave at a precise kernel-clock instant.

Top module: `tmr_sync_pair`

## Requirements
- R1: After reset both counters read 0, the slave enable and the trigger flag are 0, and the trigger line is low.
- R2: The master counts only while its enable bit is 1. With prescale value N it advances once every N+1 kernel cycles, and the first advance comes N+1 cycles after the enable becomes visible. The prescaler is held at zero while its timer is disabled, and a stopped counter keeps its value.
- R3: When a count tick finds a counter equal to its reload value, the counter wraps to 0. For the master, an update pulse one kernel cycle wide occurs in the cycle in which the counter shows 0.
- R4: Master mode field (control bits [3:1]): 3'b010 drives the update pulse onto the trigger line; 3'b001 drives the master enable level; any other value keeps the line low.
- R5: Slave source field (slave control bits [8:4]): 5'b00010 selects the master trigger line. Any other value gives no trigger at all, so neither the enable nor the flag is affected.
- R6: With the slave mode field (slave control bits [3:1]) at 3'b110, a rising edge of the selected trigger sets the slave enable one kernel cycle after the trigger goes high. The enable stays set after the trigger falls.
- R7: Every rising edge of the selected trigger sets the trigger flag in any slave mode. The flag is cleared only by writing 0 to bit 0 of the flag register, and writing 1 there has no effect. A set and a clear in the same cycle leave the flag set.
- R8: A write to either counter register loads that value, and the counter continues counting from it.
- R9: Writing 0 to the slave enable bit stops the slave counter. A later trigger edge in trigger mode sets the enable again.
- R10: With a slave mode other than 3'b110, a trigger edge leaves the slave enable unchanged.
- R11: Register addresses: 0 master control {mode[3:1], enable[0]}, 1 master prescale, 2 master reload, 3 master counter, 4 slave control {source[8:4], mode[3:1], enable[0]}, 5 slave prescale, 6 slave reload, 7 slave counter, 8 flag (bit 0). A write takes effect at the clock edge on which `wr_en_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | DATA_W | Register write data |
| mst_cnt_o | output | CNT_W | Master counter value |
| slv_cnt_o | output | CNT_W | Slave counter value |
| mst_trgo_o | output | 1 | Master trigger line |
| slv_cen_o | output | 1 | Slave counter enable |
| slv_trig_flag_o | output | 1 | Sticky slave trigger flag |

## Verification
A wrong prescaler phase shows first on `mst_cnt_o`, one kernel cycle early or late at the first advance. After that it shifts the update pulse and the slave start by the same amount. A broken edge detector or source decode shows within one cycle of the trigger pulse, because `slv_cen_o` and `slv_trig_flag_o` fail to rise, or rise when they should not. A faulty flag or enable clear path shows on the next cycle after the write. The scoreboard pins each expectation to an exact kernel cycle, so a one-cycle skew is reported as a mismatch and is not absorbed.

// File: rtl/tmr_sync_pkg.sv
package tmr_sync_pkg;
  localparam int ADDR_W = 4;
  localparam int CTRL_W = 9;

  localparam logic [ADDR_W-1:0] A_MST_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_MST_PSC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MST_ARR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MST_CNT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SLV_CTRL = 4'd4;
  localparam logic [ADDR_W-1:0] A_SLV_PSC  = 4'd5;
  localparam logic [ADDR_W-1:0] A_SLV_ARR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SLV_CNT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_FLAG     = 4'd8;

  localparam logic [2:0] MMS_ENABLE = 3'b001;
  localparam logic [2:0] MMS_UPDATE = 3'b010;
  localparam logic [2:0] SMODE_TRIG = 3'b110;
  localparam logic [4:0] TSEL_MST   = 5'b00010;
endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uev_o
);
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             uev_q;
  logic             tick;

  // prescaler sits at zero while disabled, so the first tick lands psc+1 cycles after enable
  assign tick = cen_i && (psc_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      cnt_q <= '0;
      uev_q <= 1'b0;
    end else begin
      uev_q <= 1'b0;
      if (!cen_i || tick) psc_q <= '0;
      else                psc_q <= psc_q + 1'b1;
      if (cnt_wr_i) begin
        cnt_q <= cnt_wdata_i;
      end else if (tick) begin
        if (cnt_q == arr_i) begin
          cnt_q <= '0;
          uev_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign uev_o = uev_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_i && !cnt_wr_i) |=> $stable(cnt_o));
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uev_o |-> (cnt_o == '0));
  assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl import tmr_sync_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mst_trgo_i,
  input  logic [4:0] tsel_i,
  input  logic [2:0] smode_i,
  input  logic       sw_cen_wr_i,
  input  logic       sw_cen_i,
  input  logic       flag_wr_i,
  input  logic       flag_wdata_i,
  output logic       cen_o,
  output logic       flag_o
);
  logic trig_in, trig_q, trig_edge;
  logic cen_q, flag_q;

  assign trig_in   = (tsel_i == TSEL_MST) ? mst_trgo_i : 1'b0;
  assign trig_edge = trig_in && !trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      cen_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      trig_q <= trig_in;
      // hardware start wins over a same-cycle software write
      if (trig_edge && smode_i == SMODE_TRIG) cen_q <= 1'b1;
      else if (sw_cen_wr_i)                   cen_q <= sw_cen_i;
      if (trig_edge)                          flag_q <= 1'b1;
      else if (flag_wr_i && !flag_wdata_i)    flag_q <= 1'b0;
    end
  end

  assign cen_o  = cen_q;
  assign flag_o = flag_q;

  assert_trig_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_edge && smode_i == SMODE_TRIG) |=> (cen_o && flag_o));
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_wr_i && !flag_wdata_i));
  assert_no_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_cen_wr_i && smode_i != SMODE_TRIG && !cen_o) |=> !cen_o);
endmodule

// File: rtl/tmr_sync_pair.sv
module tmr_sync_pair import tmr_sync_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  localparam int WIDE_W = (CNT_W > PSC_W) ? CNT_W : PSC_W,
  localparam int DATA_W = (WIDE_W > CTRL_W) ? WIDE_W : CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  mst_cnt_o,
  output logic [CNT_W-1:0]  slv_cnt_o,
  output logic              mst_trgo_o,
  output logic              slv_cen_o,
  output logic              slv_trig_flag_o
);
  logic             mst_cen_q;
  logic [2:0]       mms_q, smode_q;
  logic [4:0]       tsel_q;
  logic [PSC_W-1:0] mst_psc_q, slv_psc_q;
  logic [CNT_W-1:0] mst_arr_q, slv_arr_q;
  logic             mst_uev, slv_uev_unused;
  logic             wr_mst_cnt, wr_slv_cnt, wr_slv_ctrl, wr_flag;

  assign wr_mst_cnt  = wr_en_i && (wr_addr_i == A_MST_CNT);
  assign wr_slv_cnt  = wr_en_i && (wr_addr_i == A_SLV_CNT);
  assign wr_slv_ctrl = wr_en_i && (wr_addr_i == A_SLV_CTRL);
  assign wr_flag     = wr_en_i && (wr_addr_i == A_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_cen_q <= 1'b0;
      mms_q     <= '0;
      smode_q   <= '0;
      tsel_q    <= '0;
      mst_psc_q <= '0;
      slv_psc_q <= '0;
      mst_arr_q <= '0;
      slv_arr_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_MST_CTRL: begin
          mst_cen_q <= wr_data_i[0];
          mms_q     <= wr_data_i[3:1];
        end
        A_MST_PSC: mst_psc_q <= wr_data_i[PSC_W-1:0];
        A_MST_ARR: mst_arr_q <= wr_data_i[CNT_W-1:0];
        A_SLV_CTRL: begin
          smode_q <= wr_data_i[3:1];
          tsel_q  <= wr_data_i[8:4];
        end
        A_SLV_PSC: slv_psc_q <= wr_data_i[PSC_W-1:0];
        A_SLV_ARR: slv_arr_q <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (mms_q)
      MMS_UPDATE: mst_trgo_o = mst_uev;
      MMS_ENABLE: mst_trgo_o = mst_cen_q;
      default:    mst_trgo_o = 1'b0;
    endcase
  end

  tmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_mst (
    .clk_i(clk_i), .rst_ni(rst_ni), .cen_i(mst_cen_q),
    .psc_i(mst_psc_q), .arr_i(mst_arr_q),
    .cnt_wr_i(wr_mst_cnt), .cnt_wdata_i(wr_data_i[CNT_W-1:0]),
    .cnt_o(mst_cnt_o), .uev_o(mst_uev)
  );

  tmr_slave_ctrl u_slv_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mst_trgo_i(mst_trgo_o),
    .tsel_i(tsel_q), .smode_i(smode_q),
    .sw_cen_wr_i(wr_slv_ctrl), .sw_cen_i(wr_data_i[0]),
    .flag_wr_i(wr_flag), .flag_wdata_i(wr_data_i[0]),
    .cen_o(slv_cen_o), .flag_o(slv_trig_flag_o)
  );

  tmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_slv (
    .clk_i(clk_i), .rst_ni(rst_ni), .cen_i(slv_cen_o),
    .psc_i(slv_psc_q), .arr_i(slv_arr_q),
    .cnt_wr_i(wr_slv_cnt), .cnt_wdata_i(wr_data_i[CNT_W-1:0]),
    .cnt_o(slv_cnt_o), .uev_o(slv_uev_unused)
  );

  assert_trgo_upd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mms_q == MMS_UPDATE && mst_trgo_o) |-> (mst_cnt_o == '0));
  assert_trgo_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mms_q != MMS_UPDATE && mms_q != MMS_ENABLE) |-> !mst_trgo_o);
endmodule

// File: tb/tmr_sync_pair_tb.sv
module tmr_sync_pair_tb;
  localparam int CW = 16;
  localparam int S_MCNT = 0, S_SCNT = 1, S_TRGO = 2, S_SCEN = 3, S_FLAG = 4;

  typedef struct {
    int          at;
    int          sig;
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] mst_cnt, slv_cnt;
  logic          mst_trgo, slv_cen, slv_flag;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_sync_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mst_cnt_o(mst_cnt), .slv_cnt_o(slv_cnt),
    .mst_trgo_o(mst_trgo), .slv_cen_o(slv_cen), .slv_trig_flag_o(slv_flag)
  );

  function automatic logic [31:0] probe(int s);
    case (s)
      S_MCNT:  return 32'(mst_cnt);
      S_SCNT:  return 32'(slv_cnt);
      S_TRGO:  return 32'(mst_trgo);
      S_SCEN:  return 32'(slv_cen);
      default: return 32'(slv_flag);
    endcase
  endfunction

  task automatic expect_at(int at, int sig, logic [31:0] val, string tag);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: 2 ns after each rising edge, away from the driver's falling edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].at == cyc) begin
          n_cmp++;
          if (probe(sb_q[i].sig) !== sb_q[i].val) begin
            n_bad++;
            $display("FAIL %s cyc=%0d sig=%0d actual=%0h expected=%0h",
                     sb_q[i].tag, cyc, sb_q[i].sig, probe(sb_q[i].sig), sb_q[i].val);
          end
          sb_q.delete(i);
        end
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] mctl(logic [2:0] mode, logic en);
    return CW'({mode, en});
  endfunction

  function automatic logic [CW-1:0] sctl(logic [4:0] src, logic [2:0] mode, logic en);
    return CW'({src, mode, en});
  endfunction

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      n_bad += sb_q.size();
      $display("FAIL unchecked items=%0d actual=%0d expected=0", sb_q.size(), sb_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int e, v;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    expect_at(cyc + 1, S_MCNT, 0, "R1");
    expect_at(cyc + 1, S_SCNT, 0, "R1");
    expect_at(cyc + 1, S_TRGO, 0, "R1");
    expect_at(cyc + 1, S_SCEN, 0, "R1");
    expect_at(cyc + 1, S_FLAG, 0, "R1");
    idle(2);

    // master /3, reload 3; slave triggered by master update (R11 map)
    wr(4'd1, 16'd2);
    wr(4'd2, 16'd3);
    wr(4'd5, 16'd0);
    wr(4'd6, 16'd100);
    wr(4'd4, sctl(5'b00010, 3'b110, 1'b0));
    idle(3);
    expect_at(cyc + 3, S_MCNT, 0, "R2");
    e = cyc + 1;
    expect_at(e + 2,  S_MCNT, 0, "R2");
    expect_at(e + 3,  S_MCNT, 1, "R2");
    expect_at(e + 6,  S_MCNT, 2, "R2");
    expect_at(e + 9,  S_MCNT, 3, "R3");
    expect_at(e + 12, S_MCNT, 0, "R3");
    expect_at(e + 11, S_TRGO, 0, "R4");
    expect_at(e + 12, S_TRGO, 1, "R4");
    expect_at(e + 13, S_TRGO, 0, "R3");
    expect_at(e + 12, S_SCEN, 0, "R6");
    expect_at(e + 13, S_SCEN, 1, "R6");
    expect_at(e + 12, S_FLAG, 0, "R7");
    expect_at(e + 13, S_FLAG, 1, "R7");
    expect_at(e + 14, S_SCNT, 1, "R6");
    expect_at(e + 20, S_SCEN, 1, "R6");
    expect_at(e + 20, S_SCNT, 7, "R6");
    expect_at(e + 30, S_SCNT, 17, "R6");
    wr(4'd0, mctl(3'b010, 1'b1));
    idle(31);
    // stop master: counter holds (R2)
    wr(4'd0, mctl(3'b010, 1'b0));
    expect_at(cyc + 5, S_MCNT, 2, "R2");
    // flag: writing 1 ignored, writing 0 clears (R7)
    expect_at(cyc + 1, S_FLAG, 1, "R7");
    wr(4'd8, 16'd1);
    expect_at(cyc + 1, S_FLAG, 0, "R7");
    wr(4'd8, 16'd0);

    // software stops slave (R9)
    expect_at(cyc + 1, S_SCEN, 0, "R9");
    wr(4'd4, sctl(5'b00010, 3'b110, 1'b0));
    idle(1);
    v = int'(slv_cnt);
    expect_at(cyc + 4, S_SCNT, v, "R9");
    idle(5);
    // preload counters (R8), restart master fast
    expect_at(cyc + 1, S_SCNT, 16'h40, "R8");
    wr(4'd7, 16'h40);
    wr(4'd1, 16'd0);
    expect_at(cyc + 1, S_MCNT, 1, "R8");
    wr(4'd3, 16'd1);
    e = cyc + 1;
    expect_at(e + 1, S_MCNT, 2, "R8");
    expect_at(e + 3, S_MCNT, 0, "R3");
    expect_at(e + 3, S_TRGO, 1, "R4");
    expect_at(e + 3, S_SCEN, 0, "R9");
    expect_at(e + 4, S_SCEN, 1, "R9");
    expect_at(e + 4, S_FLAG, 1, "R7");
    expect_at(e + 4, S_SCNT, 16'h40, "R8");
    expect_at(e + 6, S_SCNT, 16'h42, "R8");
    wr(4'd0, mctl(3'b010, 1'b1));
    idle(8);

    // slave mode off: trigger sets flag, not enable (R10)
    wr(4'd0, mctl(3'b010, 1'b0));
    idle(3);
    wr(4'd4, sctl(5'b00010, 3'b000, 1'b0));
    expect_at(cyc + 1, S_FLAG, 0, "R7");
    wr(4'd8, 16'd0);
    expect_at(cyc + 1, S_SCEN, 0, "R10");
    wr(4'd0, mctl(3'b010, 1'b1));
    idle(10);
    expect_at(cyc + 1, S_SCEN, 0, "R10");
    expect_at(cyc + 1, S_FLAG, 1, "R7");
    idle(2);

    // unselected source: no trigger at all (R5)
    wr(4'd0, mctl(3'b010, 1'b0));
    idle(3);
    wr(4'd4, sctl(5'b00011, 3'b110, 1'b0));
    wr(4'd8, 16'd0);
    wr(4'd0, mctl(3'b010, 1'b1));
    idle(10);
    expect_at(cyc + 1, S_SCEN, 0, "R5");
    expect_at(cyc + 1, S_FLAG, 0, "R5");
    idle(2);

    // enable-level trigger mode and silent mode (R4)
    wr(4'd0, mctl(3'b010, 1'b0));
    idle(3);
    wr(4'd4, sctl(5'b00010, 3'b110, 1'b0));
    wr(4'd8, 16'd0);
    expect_at(cyc + 1, S_TRGO, 0, "R4");
    wr(4'd0, mctl(3'b001, 1'b0));
    idle(2);
    expect_at(cyc + 1, S_TRGO, 1, "R4");
    expect_at(cyc + 1, S_SCEN, 0, "R6");
    expect_at(cyc + 2, S_SCEN, 1, "R6");
    wr(4'd0, mctl(3'b001, 1'b1));
    idle(3);
    expect_at(cyc + 1, S_TRGO, 0, "R4");
    wr(4'd0, mctl(3'b000, 1'b1));
    expect_at(cyc + 8, S_TRGO, 0, "R4");
    idle(12);
    finish_run();
  end
endmodule